// File: doc/BRIEF.md
# Periodic Microsecond Interval Timer

This block raises a periodic timer interrupt at an interval that software sets in microseconds. Software reaches it through three byte-wide registers on a small register port. Two staging registers hold the upper and lower bytes of a 16-bit interval. A control register enables the timer, and a self-clearing command bit in it copies the staged bytes into the active interval latch. Staged bytes have no effect until that command is written. Reads of the two byte addresses return the active latch, never the live count.

A prescaler divides the system clock by `TICKS_PER_US` to make a one-microsecond tick. A 16-bit countdown runs on that tick and fires when the latched number of microseconds has passed. On each expiry it emits a one-cycle `irq_set` pulse and reloads itself. Every access to the control register, read or write, emits a one-cycle `irq_release` pulse so that the external interrupt controller can acknowledge the timer source. The interrupt controller itself is outside this block.

Top module: `itimer_top`

## Requirements
- R1: After reset the timer is disabled, the active interval is 0, `irq_set` and `irq_release` are low, and every register address reads 0.
- R2: Writes to select 0 (upper staging byte) or select 1 (lower staging byte) do not change the value read back from select 0 or select 1. Those reads keep returning the active latch until a load command is written.
- R3: A control write (select 2) with bit 6 set loads the active latch with the upper staging byte as bits 15:8 and the lower staging byte as bits 7:0. Afterwards select 0 reads bits 15:8 and select 1 reads bits 7:0.
- R4: A read of select 2 returns the enable state in bit 7 and 0 in bits 6:0, so the load command never reads back as 1.
- R5: Take a control write with bit 7 set that leaves an active latch L other than 0, and let T be `TICKS_PER_US`. `irq_set` is then high for one cycle exactly L*T cycles after the write edge, and again every L*T cycles after that.
- R6: No `irq_set` pulse occurs while the timer is disabled or while the active latch is 0.
- R7: Every control write restarts the period from its own clock edge, and no `irq_set` occurs on that edge.
- R8: `irq_release` is high for exactly the one cycle after each edge that samples a read or write of select 2. It is low after every other cycle.
- R9: Select 3 is unused. Writes to it change nothing, and reads of it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one access per cycle |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 upper byte, 1 lower byte, 2 control, 3 unused |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current select (combinational) |
| irq_set | output | 1 | One-cycle pulse on each interval expiry |
| irq_release | output | 1 | One-cycle pulse after each control access |

## Verification
A wrong latch or staging value appears on the very next read of select 0 or 1. It also shifts the next `irq_set` by whole multiples of the tick. A prescaler or countdown that drifts by even one cycle moves the first pulse after a control write. That pulse is compared in the exact cycle it should appear, so the error shows within one interval. A missed restart or a wrong release decode appears one cycle after the offending control access.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

    localparam int BYTE_W = 8;
    localparam int IVAL_W = 2 * BYTE_W;
    localparam int SEL_W  = 2;

    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_LOAD_BIT = 6;

    typedef enum logic [SEL_W-1:0] {
        SEL_IVAL_HI = 2'd0,
        SEL_IVAL_LO = 2'd1,
        SEL_CTRL    = 2'd2,
        SEL_SPARE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] stage_hi;
        logic [BYTE_W-1:0] stage_lo;
        logic [IVAL_W-1:0] latch;
        logic              ack;
    } regs_state_t;

    typedef struct packed {
        logic [IVAL_W-1:0] cnt;
        logic              fire;
    } cdown_state_t;

endpackage

// File: rtl/itimer_regs.sv
module itimer_regs
    import itimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              en,
    output logic [IVAL_W-1:0] latch,
    output logic [IVAL_W-1:0] latch_next,
    output logic              restart,
    output logic              ack_pulse
);

    regs_state_t st_d, st_q;
    reg_sel_e    sel_e;

    always_comb begin
        sel_e   = reg_sel_e'(sel);
        st_d    = st_q;
        restart = 1'b0;
        st_d.ack = (wr_en || rd_en) && (sel_e == SEL_CTRL);
        if (wr_en) begin
            case (sel_e)
                SEL_IVAL_HI: st_d.stage_hi = wdata;
                SEL_IVAL_LO: st_d.stage_lo = wdata;
                SEL_CTRL: begin
                    st_d.en = wdata[CTRL_EN_BIT];
                    if (wdata[CTRL_LOAD_BIT]) begin
                        st_d.latch = {st_q.stage_hi, st_q.stage_lo};
                    end
                    restart = 1'b1;
                end
                default: ;
            endcase
        end
        case (sel_e)
            SEL_IVAL_HI: rdata = st_q.latch[IVAL_W-1:BYTE_W];
            SEL_IVAL_LO: rdata = st_q.latch[BYTE_W-1:0];
            SEL_CTRL:    rdata = {st_q.en, {(BYTE_W-1){1'b0}}};
            default:     rdata = '0;
        endcase
        latch_next = st_d.latch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en        = st_q.en;
    assign latch     = st_q.latch;
    assign ack_pulse = st_q.ack;

endmodule

// File: rtl/itimer_prescaler.sv
module itimer_prescaler #(
    parameter int TICKS_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);

    localparam int PW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_US - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        tick  = run && (pre_q == LAST);
        pre_d = pre_q;
        if (clear)      pre_d = '0;
        else if (tick)  pre_d = '0;
        else if (run)   pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/itimer_countdown.sv
module itimer_countdown
    import itimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [IVAL_W-1:0] load_val,
    input  logic [IVAL_W-1:0] latch,
    input  logic              run,
    input  logic              tick,
    output logic              fire
);

    cdown_state_t cd_d, cd_q;

    always_comb begin
        cd_d      = cd_q;
        cd_d.fire = 1'b0;
        if (restart) begin
            cd_d.cnt = load_val;
        end else if (run && tick) begin
            if (cd_q.cnt <= IVAL_W'(1)) begin
                cd_d.cnt  = latch;
                cd_d.fire = 1'b1;
            end else begin
                cd_d.cnt = cd_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cd_q <= '0;
        else        cd_q <= cd_d;
    end

    assign fire = cd_q.fire;

endmodule

// File: rtl/itimer_top.sv
module itimer_top
    import itimer_pkg::*;
#(
    parameter int TICKS_PER_US = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq_set,
    output logic              irq_release
);

    logic              en_val;
    logic [IVAL_W-1:0] latch_val;
    logic [IVAL_W-1:0] latch_next;
    logic              restart;
    logic              running;
    logic              tick;

    itimer_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .rd_en      (reg_rd),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .en         (en_val),
        .latch      (latch_val),
        .latch_next (latch_next),
        .restart    (restart),
        .ack_pulse  (irq_release)
    );

    assign running = en_val && (latch_val != '0);

    itimer_prescaler #(
        .TICKS_PER_US (TICKS_PER_US)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .clear (restart),
        .tick  (tick)
    );

    itimer_countdown u_cdown (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .load_val (latch_next),
        .latch    (latch_val),
        .run      (running),
        .tick     (tick),
        .fire     (irq_set)
    );

endmodule

// File: rtl/itimer_chk.sv
module itimer_chk
    import itimer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [SEL_W-1:0]  reg_sel,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic [BYTE_W-1:0] reg_rdata,
    input logic              irq_set,
    input logic              irq_release,
    input logic [IVAL_W-1:0] latch_val
);

    logic ctrl_acc;
    assign ctrl_acc = (reg_wr || reg_rd) && (reg_sel == 2'd2);

    // R8
    ack_after_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_acc |=> irq_release);

    // R8
    no_stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_acc |=> !irq_release);

    // R7
    no_fire_on_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd2) |=> !irq_set);

    // R6
    fire_needs_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |-> (latch_val != '0));

    // R2
    latch_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel == 2'd2 && reg_wdata[6]) |=> $stable(latch_val));

    // R4
    ctrl_read_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == 2'd2) |-> (reg_rdata[6:0] == 7'd0));

    // R9
    spare_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == 2'd3) |-> (reg_rdata == '0));

endmodule

bind itimer_top itimer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .irq_set     (irq_set),
    .irq_release (irq_release),
    .latch_val   (latch_val)
);

// File: tb/itimer_top_test.sv
module itimer_top_test;

    localparam int TPU = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq_set;
    logic       irq_release;

    int vectors = 0;
    int miscompares = 0;

    // model state
    logic        m_en = 1'b0;
    logic [7:0]  m_hi = 8'd0;
    logic [7:0]  m_lo = 8'd0;
    logic [15:0] m_latch = 16'd0;
    int          m_cyc = 0;
    logic        exp_set = 1'b0;
    logic        exp_rel = 1'b0;

    always #4 clk = ~clk;

    itimer_top #(.TICKS_PER_US(TPU)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq_set     (irq_set),
        .irq_release (irq_release)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [1:0] s);
        case (s)
            2'd0:    return m_latch[15:8];
            2'd1:    return m_latch[7:0];
            2'd2:    return {m_en, 7'd0};
            default: return 8'd0;
        endcase
    endfunction

    // one cycle: drive just after a negedge, compare at the next negedge
    task automatic step(input logic wr, input logic rd, input logic [1:0] sel,
                        input logic [7:0] wd);
        reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd;
        #1;
        if (rd) begin
            if (sel == 2'd2)      chk("R4 control readback", reg_rdata, exp_rdata(sel));
            else if (sel == 2'd3) chk("R9 spare read", reg_rdata, exp_rdata(sel));
            else                  chk("R2 R3 interval readback", reg_rdata, exp_rdata(sel));
        end
        exp_rel = (wr || rd) && (sel == 2'd2);
        exp_set = 1'b0;
        if (wr && sel == 2'd0) m_hi = wd;
        if (wr && sel == 2'd1) m_lo = wd;
        if (wr && sel == 2'd2) begin
            m_en = wd[7];
            if (wd[6]) m_latch = {m_hi, m_lo};
            m_cyc = 0;
        end else if (m_en && m_latch != 16'd0) begin
            m_cyc++;
            if (m_cyc == int'(m_latch) * TPU) begin
                exp_set = 1'b1;
                m_cyc = 0;
            end
        end
        @(negedge clk);
        chk("R5 R6 R7 irq_set", irq_set, exp_set);
        chk("R8 irq_release", irq_release, exp_rel);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 8'd0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq_set after reset", irq_set, 0);
        chk("R1 irq_release after reset", irq_release, 0);
        for (int s = 0; s < 4; s++) begin
            reg_sel = 2'(s);
            #1;
            chk("R1 register reads zero", reg_rdata, 0);
        end

        // R2: staging writes do not reach the readback
        step(1'b1, 1'b0, 2'd0, 8'h00);
        step(1'b1, 1'b0, 2'd1, 8'h05);
        step(1'b0, 1'b1, 2'd0, 8'h00);
        step(1'b0, 1'b1, 2'd1, 8'h00);
        // R3 load and R5 enable with L=5
        step(1'b1, 1'b0, 2'd2, 8'hC0);
        step(1'b0, 1'b1, 2'd1, 8'h00);
        step(1'b0, 1'b1, 2'd2, 8'h00);
        idle(40);
        // R7 restart mid-period without reload
        idle(7);
        step(1'b1, 1'b0, 2'd2, 8'h80);
        idle(20);
        // R9 spare address write and read
        step(1'b1, 1'b0, 2'd3, 8'hFF);
        step(1'b0, 1'b1, 2'd3, 8'h00);
        // minimum interval L=1
        step(1'b1, 1'b0, 2'd1, 8'h01);
        step(1'b1, 1'b0, 2'd2, 8'hC0);
        idle(12);
        // R6 interval zero while enabled
        step(1'b1, 1'b0, 2'd1, 8'h00);
        step(1'b1, 1'b0, 2'd2, 8'hC0);
        idle(20);
        // R6 disabled with nonzero interval
        step(1'b1, 1'b0, 2'd1, 8'h04);
        step(1'b1, 1'b0, 2'd2, 8'h40);
        idle(30);
        // large upper byte readback
        step(1'b1, 1'b0, 2'd0, 8'hA5);
        step(1'b1, 1'b0, 2'd2, 8'h40);
        step(1'b0, 1'b1, 2'd0, 8'h00);
        step(1'b0, 1'b1, 2'd1, 8'h00);
        step(1'b1, 1'b0, 2'd0, 8'h00);

        // constrained random traffic
        for (int i = 0; i < 6000; i++) begin
            int unsigned r = $urandom % 100;
            if (r < 88) begin
                step(1'b0, 1'b0, 2'd0, 8'd0);
            end else begin
                logic [1:0] s = 2'($urandom % 4);
                logic [7:0] d = 8'($urandom);
                logic       w = ($urandom % 2) == 0;
                if (w && s == 2'd0) d = (($urandom % 8) == 0) ? 8'h01 : 8'h00;
                if (w && s == 2'd1) d = 8'($urandom % 12);
                step(w, !w, s, d);
            end
        end
        idle(5);
        summary();
        $finish;
    end

endmodule